// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Fault Shutdown

This block generates a pulse-width modulated output from an up-counter that wraps at a programmable period. Software may write a new duty value into a shadow buffer at any time. The shadow value moves into the active duty register only when the counter wraps. Because of this, a duty change never cuts a period short or adds a stray edge. Before PWM is enabled, the active duty register can be preloaded directly, so the first period has a known width. Once the channel is in a PWM mode, the active duty register can no longer be written from outside.

Two PWM modes exist. In the plain mode the channel ignores the fault input. In the protected mode, a low level on the active-low fault input drops the output enable straight away, through logic only. A synchronized copy of the fault then sets a sticky fault status and pulses a channel interrupt. The shutdown holds until the fault input is high again and the mode register is written once more. A period interrupt pulses once per wrap, so software can time its buffer updates.

Top module: `dbpwm_top`

## Requirements
- R1: While `run` is high the counter advances by one per clock and goes from `period` to 0, giving `period`+1 counts per period; while `run` is low it holds its value.
- R2: `duty_buf_wr` updates the shadow duty at any time; the active duty (`duty_act`) takes the shadow value only on the clock where `run` is high and the counter equals `period`.
- R3: `duty_pre_wr` loads `duty_act` directly only while the mode register is not a PWM mode (3'b110 or 3'b111); otherwise the write is ignored.
- R4: In a PWM mode, `pwm_out` is high while the counter is below `duty_act` and low from the count equal to it; in any other mode `pwm_out` is low.
- R5: An active duty of 0 gives a constant low output; a duty above `period` gives a constant high output; a duty equal to `period` gives an output that is low for exactly one count per period.
- R6: `period_irq` is a one-clock pulse in the cycle after a wrap, when the counter reads 0.
- R7: In mode 3'b110 the fault input has no effect on `pwm_oe`, `pwm_out` or `fault_sts`.
- R8: In mode 3'b111 a low `fault_n` drives `pwm_oe` and `pwm_out` low in the same cycle, with no clock edge needed.
- R9: In mode 3'b111 a fault held for SYNC_STAGES clocks sets `fault_sts` and gives a one-clock `fault_irq` pulse.
- R10: `fault_sts` stays set, and `pwm_oe` stays low, until the synchronized fault has cleared and `mode_wr` is pulsed; a mode write while the fault is still present leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter enable |
| period | input | CNT_W | Last count value of a period |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_in | input | 3 | Mode value (3'b110 PWM, 3'b111 PWM with fault) |
| duty_buf_wr | input | 1 | Write strobe for the shadow duty |
| duty_buf_in | input | CNT_W | Shadow duty value |
| duty_pre_wr | input | 1 | Preload strobe for the active duty |
| duty_pre_in | input | CNT_W | Preload value |
| fault_n | input | 1 | Active-low fault input, asynchronous |
| pwm_out | output | 1 | PWM output level |
| pwm_oe | output | 1 | Output enable; low means high impedance |
| count | output | CNT_W | Counter value |
| duty_act | output | CNT_W | Active duty register |
| period_irq | output | 1 | Period-wrap pulse |
| fault_sts | output | 1 | Sticky fault status |
| fault_irq | output | 1 | Fault interrupt pulse |

## Verification
Assertions check on every cycle that the counter wraps to zero after the period value, that the active duty changes only on a reload or an allowed preload, that the period pulse coincides with a zero count, that a latched fault keeps the enable low, and that the fault status survives any cycle without a mode write. The effect of the async fault input between clock edges, the output width in the three edge cases of duty, and whether a mode write releases the shutdown or not are shown only by the bench scenarios. A cycle-level reference model compares every output on each cycle.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
   localparam logic [2:0] MODE_PWM     = 3'b110;
   localparam logic [2:0] MODE_PWM_FLT = 3'b111;

   function automatic logic is_pwm(input logic [2:0] m);
      return m[2:1] == 2'b11;
   endfunction

   function automatic logic is_flt(input logic [2:0] m);
      return m == MODE_PWM_FLT;
   endfunction
endpackage

// File: rtl/dbpwm_timebase.sv
module dbpwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap,
   output logic             tick
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("dbpwm_timebase: CNT_W must be at least 2");
   end

   assign wrap = run && (cnt == period);

   always_comb begin
      cnt_nxt = cnt;
      if (wrap)     cnt_nxt = '0;
      else if (run) cnt_nxt = cnt + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         cnt  <= cnt_nxt;
         tick <= wrap;
      end
   end

   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == period) |=> (cnt == '0));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> $stable(cnt));
   a_r6_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (cnt == '0));
endmodule

// File: rtl/dbpwm_duty.sv
module dbpwm_duty #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_wr,
   input  logic [CNT_W-1:0] buf_in,
   input  logic             pre_wr,
   input  logic [CNT_W-1:0] pre_in,
   input  logic             locked,
   input  logic             load,
   output logic [CNT_W-1:0] act,
   output logic [CNT_W-1:0] act_nxt
);
   logic [CNT_W-1:0] shadow;

   always_comb begin
      act_nxt = act;
      if (load)                 act_nxt = shadow;
      else if (pre_wr && !locked) act_nxt = pre_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
      end else begin
         if (buf_wr) shadow <= buf_in;
         act <= act_nxt;
      end
   end

   a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act == $past(shadow)));
   a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !load) |=> $stable(act));
endmodule

// File: rtl/dbpwm_fault.sv
module dbpwm_fault #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_n,
   input  logic flt_mode,
   input  logic mode_wr,
   output logic sts,
   output logic irq
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen;
   logic                   set_c;
   logic                   clr_c;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dbpwm_fault: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~fault_n};
   end

   assign seen  = sync_q[SYNC_STAGES-1];
   assign clr_c = mode_wr && !seen;
   assign set_c = flt_mode && seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts <= 1'b0;
         irq <= 1'b0;
      end else begin
         irq <= set_c && !sts;
         if (clr_c)      sts <= 1'b0;
         else if (set_c) sts <= 1'b1;
      end
   end

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts && !mode_wr) |=> sts);
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r9_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> sts);
endmodule

// File: rtl/dbpwm_top.sv
module dbpwm_top
   import dbpwm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit FAULT_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic             mode_wr,
   input  logic [2:0]       mode_in,
   input  logic             duty_buf_wr,
   input  logic [CNT_W-1:0] duty_buf_in,
   input  logic             duty_pre_wr,
   input  logic [CNT_W-1:0] duty_pre_in,
   input  logic             fault_n,
   output logic             pwm_out,
   output logic             pwm_oe,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] duty_act,
   output logic             period_irq,
   output logic             fault_sts,
   output logic             fault_irq
);
   logic [2:0]       mode_q;
   logic [2:0]       mode_d;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] act_nxt;
   logic             wrap;
   logic             pwm_q;
   logic             flt_mode;

   assign mode_d   = mode_wr ? mode_in : mode_q;
   assign flt_mode = is_flt(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pwm_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         pwm_q  <= is_pwm(mode_d) && (cnt_nxt < act_nxt);
      end
   end

   dbpwm_timebase #(.CNT_W(CNT_W)) i_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .period  (period),
      .cnt     (count),
      .cnt_nxt (cnt_nxt),
      .wrap    (wrap),
      .tick    (period_irq)
   );

   dbpwm_duty #(.CNT_W(CNT_W)) i_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .buf_wr  (duty_buf_wr),
      .buf_in  (duty_buf_in),
      .pre_wr  (duty_pre_wr),
      .pre_in  (duty_pre_in),
      .locked  (is_pwm(mode_q)),
      .load    (wrap),
      .act     (duty_act),
      .act_nxt (act_nxt)
   );

   if (FAULT_EN) begin : g_fault
      dbpwm_fault #(.SYNC_STAGES(SYNC_STAGES)) i_fault (
         .clk      (clk),
         .rst_n    (rst_n),
         .fault_n  (fault_n),
         .flt_mode (flt_mode),
         .mode_wr  (mode_wr),
         .sts      (fault_sts),
         .irq      (fault_irq)
      );
      assign pwm_oe = !(flt_mode && (!fault_n || fault_sts));
   end else begin : g_no_fault
      assign fault_sts = 1'b0;
      assign fault_irq = 1'b0;
      assign pwm_oe    = 1'b1;
   end

   assign pwm_out = pwm_q && pwm_oe;

   a_r10_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_mode && fault_sts) |-> !pwm_oe);
   a_r4_off: assert property (@(posedge clk) disable iff (!rst_n)
      !is_pwm(mode_q) |-> !pwm_out);
   a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act == '0) |-> !pwm_out);
   a_r7_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PWM) |-> pwm_oe);
endmodule

// File: tb/test_dbpwm_top.sv
module test_dbpwm_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run = 1'b0;
   logic [W-1:0] period = '0;
   logic         mode_wr = 1'b0;
   logic [2:0]   mode_in = '0;
   logic         duty_buf_wr = 1'b0;
   logic [W-1:0] duty_buf_in = '0;
   logic         duty_pre_wr = 1'b0;
   logic [W-1:0] duty_pre_in = '0;
   logic         fault_n = 1'b1;
   logic         pwm_out, pwm_oe, period_irq, fault_sts, fault_irq;
   logic [W-1:0] count, duty_act;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dbpwm_top #(.CNT_W(W)) i_dbpwm_top (
      .clk(clk), .rst_n(rst_n), .run(run), .period(period),
      .mode_wr(mode_wr), .mode_in(mode_in),
      .duty_buf_wr(duty_buf_wr), .duty_buf_in(duty_buf_in),
      .duty_pre_wr(duty_pre_wr), .duty_pre_in(duty_pre_in),
      .fault_n(fault_n), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
      .count(count), .duty_act(duty_act), .period_irq(period_irq),
      .fault_sts(fault_sts), .fault_irq(fault_irq));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model built from the requirements
   logic [W-1:0] m_cnt, m_buf, m_act;
   logic [2:0]   m_mode;
   logic         m_s1, m_s2, m_sts, m_firq, m_tick;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_buf <= '0; m_act <= '0; m_mode <= '0;
         m_s1 <= 1'b0; m_s2 <= 1'b0; m_sts <= 1'b0; m_firq <= 1'b0; m_tick <= 1'b0;
      end else begin
         m_tick <= run && (m_cnt == period);
         if (run) m_cnt <= (m_cnt == period) ? '0 : m_cnt + 1'b1;
         if (duty_buf_wr) m_buf <= duty_buf_in;
         if (run && m_cnt == period) m_act <= m_buf;
         else if (duty_pre_wr && m_mode[2:1] != 2'b11) m_act <= duty_pre_in;
         if (mode_wr) m_mode <= mode_in;
         m_s1 <= ~fault_n;
         m_s2 <= m_s1;
         m_firq <= (m_mode == 3'b111) && m_s2 && !m_sts;
         if (mode_wr && !m_s2) m_sts <= 1'b0;
         else if (m_mode == 3'b111 && m_s2) m_sts <= 1'b1;
      end
   end

   typedef struct {
      logic         out, oe, sts, firq, tick;
      logic [W-1:0] cnt, act;
   } exp_t;
   exp_t sb_q[$];

   // driver side of the scoreboard: push the expected outputs for this cycle
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t e;
         e.oe   = !(m_mode == 3'b111 && (!fault_n || m_sts));
         e.out  = (m_mode[2:1] == 2'b11) && (m_cnt < m_act) && e.oe;
         e.sts  = m_sts;
         e.firq = m_firq;
         e.tick = m_tick;
         e.cnt  = m_cnt;
         e.act  = m_act;
         sb_q.push_back(e);
      end
   end

   // monitor: pop and compare
   always @(negedge clk) begin
      #1;
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         chk("R1 count", count, e.cnt);
         chk("R2 duty_act", duty_act, e.act);
         chk("R4 pwm_out", W'(pwm_out), W'(e.out));
         chk("R6 period_irq", W'(period_irq), W'(e.tick));
         chk("R8 pwm_oe", W'(pwm_oe), W'(e.oe));
         chk("R10 fault_sts", W'(fault_sts), W'(e.sts));
         chk("R9 fault_irq", W'(fault_irq), W'(e.firq));
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic write_mode(input logic [2:0] m);
      mode_in = m; mode_wr = 1'b1;
      step(1);
      mode_wr = 1'b0;
   endtask

   task automatic write_buf(input logic [W-1:0] d);
      duty_buf_in = d; duty_buf_wr = 1'b1;
      step(1);
      duty_buf_wr = 1'b0;
   endtask

   // count high outputs over one full period starting at a wrap
   task automatic measure(input logic [W-1:0] d, input int exp_high, input string req);
      int highs = 0;
      write_buf(d);
      @(negedge clk);
      while (period_irq !== 1'b1) @(negedge clk);
      @(negedge clk);
      while (period_irq !== 1'b1) @(negedge clk);
      for (int i = 0; i <= int'(period); i++) begin
         if (pwm_out === 1'b1) highs++;
         @(negedge clk);
      end
      chk(req, W'(highs), W'(exp_high));
      step(0);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      #1;
      // reset state
      chk("R1 reset count", count, '0);
      chk("R4 reset out", W'(pwm_out), '0);
      chk("R10 reset sts", W'(fault_sts), '0);
      period = W'(7);

      // R3: preload allowed while not in PWM mode
      duty_pre_in = W'(3); duty_pre_wr = 1'b1; step(1); duty_pre_wr = 1'b0;
      chk("R3 preload accepted", duty_act, W'(3));
      write_buf(W'(3));
      write_mode(3'b110);
      run = 1'b1;
      step(20);

      // R3: preload ignored in PWM mode
      duty_pre_in = W'(1); duty_pre_wr = 1'b1; step(1); duty_pre_wr = 1'b0;
      chk("R3 preload ignored", duty_act, W'(3));

      // R2: mid-period buffer write takes effect only at the wrap
      measure(W'(5), 5, "R2 duty 5 width");
      measure(W'(0), 0, "R5 duty zero");
      measure(W'(9), 8, "R5 duty above period");
      measure(W'(7), 7, "R5 duty equal period");
      measure(W'(2), 2, "R4 duty 2 width");

      // R1: counter holds when run low
      run = 1'b0; step(5);
      run = 1'b1; step(3);

      // R7: fault ignored in plain mode
      fault_n = 1'b0; #1;
      chk("R7 oe in plain mode", W'(pwm_oe), W'(1));
      step(6);
      chk("R7 sts in plain mode", W'(fault_sts), '0);
      fault_n = 1'b1; step(4);

      // R8/R9: protected mode
      write_mode(3'b111);
      write_buf(W'(6));
      step(10);
      fault_n = 1'b0; #1;
      chk("R8 async oe", W'(pwm_oe), '0);
      chk("R8 async out", W'(pwm_out), '0);
      step(4);
      chk("R9 sts set", W'(fault_sts), W'(1));

      // R10: mode write while fault present keeps shutdown
      write_mode(3'b111);
      step(2);
      chk("R10 sts held", W'(fault_sts), W'(1));
      fault_n = 1'b1; step(5);
      chk("R10 oe still low", W'(pwm_oe), '0);
      write_mode(3'b111);
      chk("R10 sts cleared", W'(fault_sts), '0);
      chk("R10 oe restored", W'(pwm_oe), W'(1));
      step(20);

      // second fault event, irq again
      fault_n = 1'b0; step(6); fault_n = 1'b1; step(4);
      write_mode(3'b110);
      step(10);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule